// File: doc/BRIEF.md
# Pixel Cursor Register Front End

This block sits between a 16-bit word-addressed CPU port and a bitmap frame buffer. It keeps a pixel cursor (an X and a Y coordinate) together with four configuration registers: a destination line, a drawing operation, a colour pair and a display mode. The offset of each access decides what happens to the cursor. An access can load a coordinate, step a coordinate by one, or do both on different axes.

The offset also decides whether a pixel transfer takes place. Writes in the upper half of the pixel window send a one-cycle write strobe to the frame buffer. The strobe carries the cursor after that access has moved it. Its data word is either the CPU word or a fill pattern built from the foreground colour. Certain reads step the cursor first and then fetch a word from the frame buffer. For these reads the block holds the port busy until the frame buffer acknowledges.

Four more offsets load the palette banks through one-hot strobes. One read offset returns the incoming scanline number reduced modulo eleven.

Top module: `pixcur_front`

## Requirements
- R1: After reset, X, Y, the destination line, the operation register and the mode register read as zero. `pix_wr_stb`, `pal_wr_stb`, `pix_rd_req`, `rd_valid` and `bus_busy` are all low.
- R2: Write offsets that load the cursor:
  - 0x01 loads X.
  - 0x06 loads Y.
  - 0x03 loads X and steps Y.
  - 0x07 loads Y and steps X.
  - 0x09, 0x0B, 0x0E and 0x0F move the cursor exactly as 0x01, 0x03, 0x06 and 0x07 do.
- R3: Write offsets 0x02 and 0x0A step Y, and 0x05 and 0x0D step X. Offsets 0x00, 0x04, 0x08 and 0x0C leave the cursor alone. A step from 0xFFFF wraps to 0x0000.
- R4: A write to any offset from 0x08 to 0x0F raises `pix_wr_stb` for exactly the cycle after acceptance. `pix_x` and `pix_y` then show the cursor after the update, and `pix_wdata` shows the written word. Offsets 0x09, 0x0B, 0x0E and 0x0F are the exception, covered by R5.
- R5: For offsets 0x09, 0x0B, 0x0E and 0x0F, `pix_wdata` is the foreground colour (colour register bits 3:0) copied into all four nibbles.
- R6: Writes to offsets 0x00–0x07 and 0x10–0x1F never raise `pix_wr_stb`.
- R7: Writes to 0x10, 0x11, 0x12 and 0x13 load, in that order, the destination line, operation, colour and mode registers. The destination line keeps 16 bits and the other three keep bits 7:0. They read back at the same offsets with the upper bits zero, and they drive `dest_line`, `pix_op` and `disp_mode`. In the operation register, bit 3 is XOR drawing and bits 2:0 are the width mode. In the mode register, bit 4 selects 80 columns.
- R8: A write to offset 0x14+k (k = 0..3) raises only bit k of `pal_wr_stb` in the cycle after acceptance, with `pal_wdata` equal to the written word.
- R9: A register read raises `rd_valid` in the cycle after acceptance. Offsets 0x10–0x13 return the registers of R7, 0x14 returns `scanline` mod 11, 0x15 returns X and 0x16 returns Y. Every other non-pixel offset (0x01, 0x03, 0x04, 0x06, 0x07, 0x09, 0x0B, 0x0C, 0x0E, 0x0F, 0x17–0x1F) returns zero.
- R10: Read offsets 0x00 and 0x08 fetch a pixel word at the cursor. Offsets 0x02 and 0x0A step Y before the fetch, and 0x05 and 0x0D step X before the fetch. `pix_rd_req` and `bus_busy` rise in the cycle after acceptance and hold until the first edge at which `pix_rd_ack` is high. `rd_valid` then shows `pix_rd_data` from that edge in the next cycle.
- R11: Writes to offsets 0x18–0x1F change neither the cursor nor any configuration register, and raise no strobe.
- R12: A request presented while `bus_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access request, accepted at an edge when bus_busy is low |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 16 | Write word |
| bus_busy | output | 1 | Pixel read outstanding |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| scanline | input | 16 | Current scanline number |
| pix_wr_stb | output | 1 | Pixel write strobe |
| pix_x | output | 16 | Cursor X |
| pix_y | output | 16 | Cursor Y |
| pix_wdata | output | 16 | Pixel write word |
| pix_op | output | 8 | Operation register |
| pix_rd_req | output | 1 | Pixel read request, held until acknowledge |
| pix_rd_ack | input | 1 | Pixel read acknowledge |
| pix_rd_data | input | 16 | Pixel read word |
| dest_line | output | 16 | Destination line register |
| disp_mode | output | 8 | Mode register |
| pal_wr_stb | output | 4 | One-hot palette bank write strobe |
| pal_wdata | output | 16 | Palette bank word |

## Verification
Every output is registered, so for each accepted access the effect is due in the cycle after the accepting edge. This covers the cursor update, the pixel and palette strobes and register read data. A pixel fetch is different: its data is due one cycle after the edge that samples the acknowledge. The bench drives inputs on falling edges and samples exactly one falling edge after the accepting edge, where a misplaced strobe or a late cursor update shows. For pixel fetches it varies the acknowledge delay from zero to two cycles, and checks that the request stays up until the acknowledged edge and falls right after it.

// File: rtl/pixcur_pkg.sv
package pixcur_pkg;

  typedef enum logic [3:0] {
    RS_ZERO, RS_DLINE, RS_OP, RS_COL, RS_MODE, RS_LINE, RS_X, RS_Y
  } pc_rsel_e;

  typedef struct packed {
    logic     ld_x;
    logic     ld_y;
    logic     inc_x;
    logic     inc_y;
    logic     use_fill;
    logic     pix_wr;
    logic     pix_rd;
    logic     cfg_wr;
    logic     pal_wr;
    logic [1:0] sub;
    pc_rsel_e rsel;
  } pc_act_t;

endpackage

// File: rtl/pixcur_decode.sv
module pixcur_decode
  import pixcur_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output pc_act_t           act
);

  logic [2:0] low;
  logic       hi_half;

  assign low     = addr[2:0];
  assign hi_half = addr[3];

  always_comb begin
    act      = '0;
    act.rsel = RS_ZERO;
    act.sub  = addr[1:0];
    if (!addr[4]) begin
      if (wr) begin
        unique case (low)
          3'd1: act.ld_x = 1'b1;
          3'd2: act.inc_y = 1'b1;
          3'd3: begin act.ld_x = 1'b1; act.inc_y = 1'b1; end
          3'd5: act.inc_x = 1'b1;
          3'd6: act.ld_y = 1'b1;
          3'd7: begin act.ld_y = 1'b1; act.inc_x = 1'b1; end
          default: ;
        endcase
        act.pix_wr   = hi_half;
        act.use_fill = hi_half && (low == 3'd1 || low == 3'd3 ||
                                   low == 3'd6 || low == 3'd7);
      end else begin
        unique case (low)
          3'd0: act.pix_rd = 1'b1;
          3'd2: begin act.pix_rd = 1'b1; act.inc_y = 1'b1; end
          3'd5: begin act.pix_rd = 1'b1; act.inc_x = 1'b1; end
          default: ;
        endcase
      end
    end else if (!addr[3]) begin
      if (!addr[2]) begin
        act.cfg_wr = wr;
        unique case (addr[1:0])
          2'd0: act.rsel = RS_DLINE;
          2'd1: act.rsel = RS_OP;
          2'd2: act.rsel = RS_COL;
          default: act.rsel = RS_MODE;
        endcase
      end else begin
        act.pal_wr = wr;
        unique case (addr[1:0])
          2'd0: act.rsel = RS_LINE;
          2'd1: act.rsel = RS_X;
          2'd2: act.rsel = RS_Y;
          default: act.rsel = RS_ZERO;
        endcase
      end
    end
  end

endmodule

// File: rtl/pixcur_cursor.sv
module pixcur_cursor #(
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ld_x,
  input  logic               ld_y,
  input  logic               inc_x,
  input  logic               inc_y,
  input  logic [COORD_W-1:0] load_val,
  output logic [COORD_W-1:0] x,
  output logic [COORD_W-1:0] y
);

  logic [COORD_W-1:0] x_n, y_n;

  always_comb begin
    x_n = x;
    y_n = y;
    if (en) begin
      if (ld_x)       x_n = load_val;
      else if (inc_x) x_n = x + 1'b1;
      if (ld_y)       y_n = load_val;
      else if (inc_y) y_n = y + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else begin
      x <= x_n;
      y <= y_n;
    end
  end

  // R3: an untouched axis keeps its value
  a_r3_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && (ld_x || inc_x)) |=> $stable(x));
  a_r3_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && (ld_y || inc_y)) |=> $stable(y));
  // R3: a step adds one with wrap
  a_r3_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc_x && !ld_x) |=> (x == $past(x) + 1'b1));
  // R2: a load takes the bus word
  a_r2_y_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld_y) |=> (y == $past(load_val)));

endmodule

// File: rtl/pixcur_rdctl.sv
module pixcur_rdctl #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pix,
  input  logic              start_reg,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              pix_rd_ack,
  input  logic [DATA_W-1:0] pix_rd_data,
  output logic              busy,
  output logic              pix_rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e         st, st_n;
  logic        valid_n;
  logic        cap_en;
  logic [DATA_W-1:0] cap_val;

  always_comb begin
    st_n    = st;
    valid_n = 1'b0;
    cap_en  = 1'b0;
    cap_val = reg_val;
    unique case (st)
      ST_IDLE: begin
        if (start_pix) begin
          st_n = ST_WAIT;
        end else if (start_reg) begin
          valid_n = 1'b1;
          cap_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (pix_rd_ack) begin
          st_n    = ST_IDLE;
          valid_n = 1'b1;
          cap_en  = 1'b1;
          cap_val = pix_rd_data;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rd_valid <= 1'b0;
    end else begin
      st       <= st_n;
      rd_valid <= valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) rd_data <= cap_val;
  end

  assign busy       = (st == ST_WAIT);
  assign pix_rd_req = (st == ST_WAIT);

  // R10: request stays up until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd_req && !pix_rd_ack) |=> pix_rd_req);
  // R10: acknowledged request delivers data next cycle
  a_r10_ack_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd_req && pix_rd_ack) |=> (rd_valid && !pix_rd_req));

endmodule

// File: rtl/pixcur_front.sv
module pixcur_front
  import pixcur_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int COORD_W  = 16,
  parameter int CFG_W    = 8,
  parameter int NBANK    = 4,
  parameter int LINE_MOD = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_busy,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [COORD_W-1:0] scanline,
  output logic               pix_wr_stb,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y,
  output logic [DATA_W-1:0]  pix_wdata,
  output logic [CFG_W-1:0]   pix_op,
  output logic               pix_rd_req,
  input  logic               pix_rd_ack,
  input  logic [DATA_W-1:0]  pix_rd_data,
  output logic [COORD_W-1:0] dest_line,
  output logic [CFG_W-1:0]   disp_mode,
  output logic [NBANK-1:0]   pal_wr_stb,
  output logic [DATA_W-1:0]  pal_wdata
);

  localparam int NIB = DATA_W / 4;
  localparam logic [COORD_W-1:0] LMOD = COORD_W'(LINE_MOD);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  pc_act_t act;
  logic    acc;

  assign acc = bus_req && !bus_busy;

  pixcur_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .act  (act)
  );

  pixcur_cursor #(.COORD_W(COORD_W)) u_cur (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (acc),
    .ld_x     (act.ld_x),
    .ld_y     (act.ld_y),
    .inc_x    (act.inc_x),
    .inc_y    (act.inc_y),
    .load_val (bus_wdata[COORD_W-1:0]),
    .x        (pix_x),
    .y        (pix_y)
  );

  // configuration registers
  logic [CFG_W-1:0] colour_q;
  logic             cfg_en;
  logic [3:0]       cfg_sel;

  assign cfg_en = acc && act.cfg_wr;

  always_comb begin
    cfg_sel = '0;
    if (cfg_en) cfg_sel[act.sub] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dest_line <= '0;
      pix_op    <= '0;
      disp_mode <= '0;
    end else begin
      if (cfg_sel[0]) dest_line <= bus_wdata[COORD_W-1:0];
      if (cfg_sel[1]) pix_op    <= bus_wdata[CFG_W-1:0];
      if (cfg_sel[3]) disp_mode <= bus_wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_sel[2]) colour_q <= bus_wdata[CFG_W-1:0];
  end

  // fill pattern from the foreground colour
  logic [DATA_W-1:0] fill_word;
  genvar gi;
  generate
    for (gi = 0; gi < NIB; gi++) begin : g_fill
      assign fill_word[gi*4 +: 4] = colour_q[3:0];
    end
  endgenerate

  // pixel write and palette strobes
  logic             wr_stb_n;
  logic [NBANK-1:0] pal_stb_n;

  assign wr_stb_n = acc && act.pix_wr;

  generate
    for (gi = 0; gi < NBANK; gi++) begin : g_pal
      assign pal_stb_n[gi] = acc && act.pal_wr && (act.sub == gi[1:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pix_wr_stb <= 1'b0;
      pal_wr_stb <= '0;
    end else begin
      pix_wr_stb <= wr_stb_n;
      pal_wr_stb <= pal_stb_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_stb_n)    pix_wdata <= act.use_fill ? fill_word : bus_wdata;
    if (|pal_stb_n)  pal_wdata <= bus_wdata;
  end

  // register read value
  logic [DATA_W-1:0] reg_val;

  always_comb begin
    unique case (act.rsel)
      RS_DLINE: reg_val = DATA_W'(dest_line);
      RS_OP:    reg_val = DATA_W'(pix_op);
      RS_COL:   reg_val = DATA_W'(colour_q);
      RS_MODE:  reg_val = DATA_W'(disp_mode);
      RS_LINE:  reg_val = DATA_W'(scanline % LMOD);
      RS_X:     reg_val = DATA_W'(pix_x);
      RS_Y:     reg_val = DATA_W'(pix_y);
      default:  reg_val = '0;
    endcase
  end

  pixcur_rdctl #(.DATA_W(DATA_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_q),
    .start_pix   (acc && !bus_wr && act.pix_rd),
    .start_reg   (acc && !bus_wr && !act.pix_rd),
    .reg_val     (reg_val),
    .pix_rd_ack  (pix_rd_ack),
    .pix_rd_data (pix_rd_data),
    .busy        (bus_busy),
    .pix_rd_req  (pix_rd_req),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  // R4: a pixel write strobe follows an accepted write to the upper pixel window
  a_r4_stb_source: assert property (@(posedge clk) disable iff (!rst_q)
    pix_wr_stb |-> $past(acc && bus_wr && !bus_addr[4] && bus_addr[3]));
  // R8: at most one palette bank per cycle
  a_r8_pal_onehot: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(pal_wr_stb));
  // R6: pixel and palette strobes never coincide
  a_r6_stb_excl: assert property (@(posedge clk) disable iff (!rst_q)
    !(pix_wr_stb && (|pal_wr_stb)));
  // R12: nothing is written while a fetch is outstanding
  a_r12_busy_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    bus_busy |=> !pix_wr_stb && (pal_wr_stb == '0));

endmodule

// File: tb/pixcur_front_test.sv
module pixcur_front_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_busy, rd_valid;
  logic [15:0] rd_data;
  logic [15:0] scanline;
  logic        pix_wr_stb;
  logic [15:0] pix_x, pix_y, pix_wdata;
  logic [7:0]  pix_op;
  logic        pix_rd_req, pix_rd_ack;
  logic [15:0] pix_rd_data;
  logic [15:0] dest_line;
  logic [7:0]  disp_mode;
  logic [3:0]  pal_wr_stb;
  logic [15:0] pal_wdata;

  always #5 clk = ~clk;

  pixcur_front uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_busy(bus_busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .scanline(scanline),
    .pix_wr_stb(pix_wr_stb), .pix_x(pix_x), .pix_y(pix_y),
    .pix_wdata(pix_wdata), .pix_op(pix_op), .pix_rd_req(pix_rd_req),
    .pix_rd_ack(pix_rd_ack), .pix_rd_data(pix_rd_data),
    .dest_line(dest_line), .disp_mode(disp_mode),
    .pal_wr_stb(pal_wr_stb), .pal_wdata(pal_wdata)
  );

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  // bench model of configuration state
  logic [15:0] m_dl;
  logic [7:0]  m_op, m_col, m_mode;

  // captured after a write
  logic        s_pix;
  logic [15:0] s_px, s_py, s_pd, s_pald;
  logic [3:0]  s_pal;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller is just after a falling edge
  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    s_pix = pix_wr_stb; s_px = pix_x; s_py = pix_y; s_pd = pix_wdata;
    s_pal = pal_wr_stb; s_pald = pal_wdata;
  endtask

  task automatic bus_read_reg(input logic [4:0] a, output logic [15:0] v);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R9 rd_valid", {31'b0, rd_valid}, 32'd1);
    v = rd_data;
  endtask

  task automatic bus_read_pix(input logic [4:0] a, input int dly, input logic [15:0] pd,
                              input logic [15:0] ex, input logic [15:0] ey);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R10 req up", {31'b0, pix_rd_req}, 32'd1);
    chk("R10 busy up", {31'b0, bus_busy}, 32'd1);
    chk("R10 fetch x", {16'b0, pix_x}, {16'b0, ex});
    chk("R10 fetch y", {16'b0, pix_y}, {16'b0, ey});
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R10 req held", {31'b0, pix_rd_req}, 32'd1);
    end
    pix_rd_ack = 1'b1; pix_rd_data = pd;
    @(negedge clk);
    pix_rd_ack = 1'b0; pix_rd_data = 16'h0;
    chk("R10 rd_valid", {31'b0, rd_valid}, 32'd1);
    chk("R10 rd_data", {16'b0, rd_data}, {16'b0, pd});
    chk("R10 req drop", {31'b0, pix_rd_req}, 32'd0);
  endtask

  // expected actions from R2, R3, R10: {ldx, ldy, incx, incy, fill}
  function automatic logic [4:0] exp_wr(input logic [4:0] a);
    case (a)
      5'h01: return 5'b10000;
      5'h02, 5'h0A: return 5'b00010;
      5'h03: return 5'b10010;
      5'h05, 5'h0D: return 5'b00100;
      5'h06: return 5'b01000;
      5'h07: return 5'b01100;
      5'h09: return 5'b10001;
      5'h0B: return 5'b10011;
      5'h0E: return 5'b01001;
      5'h0F: return 5'b01101;
      default: return 5'b00000;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, xa, ya, d, ex, ey, fill;
    logic [4:0]  w;
    bus_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    scanline = 0; pix_rd_ack = 0; pix_rd_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pix_wr_stb", {31'b0, pix_wr_stb}, 0);
    chk("R1 pal_wr_stb", {28'b0, pal_wr_stb}, 0);
    chk("R1 busy", {31'b0, bus_busy}, 0);
    chk("R1 pix_rd_req", {31'b0, pix_rd_req}, 0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 0);
    bus_read_reg(5'h15, v); chk("R1 x", {16'b0, v}, 0);
    bus_read_reg(5'h16, v); chk("R1 y", {16'b0, v}, 0);
    bus_read_reg(5'h10, v); chk("R1 dline", {16'b0, v}, 0);
    bus_read_reg(5'h11, v); chk("R1 op", {16'b0, v}, 0);
    bus_read_reg(5'h13, v); chk("R1 mode", {16'b0, v}, 0);
    m_dl = 0; m_op = 0; m_mode = 0;

    // write sweep over every offset
    for (int off = 0; off < 32; off++) begin
      xa = 16'h0100 + 16'(off);
      ya = 16'h0200 + 16'(off * 3);
      d  = 16'h3C00 ^ 16'(off * 16'h0111);
      bus_write(5'h01, xa);
      bus_write(5'h06, ya);
      bus_write(5'h12, 16'h5A50 | 16'(off & 15));
      m_col = 8'h50 | 8'(off & 15);
      fill = {4{m_col[3:0]}};
      bus_write(5'(off), d);
      w = exp_wr(5'(off));
      ex = w[4] ? d : (w[2] ? xa + 16'd1 : xa);
      ey = w[3] ? d : (w[1] ? ya + 16'd1 : ya);
      if (off < 16 && off[3]) begin
        chk("R4 strobe", {31'b0, s_pix}, 1);
        chk("R4 x", {16'b0, s_px}, {16'b0, ex});
        chk("R4 y", {16'b0, s_py}, {16'b0, ey});
        if (w[0]) chk("R5 fill data", {16'b0, s_pd}, {16'b0, fill});
        else      chk("R4 data", {16'b0, s_pd}, {16'b0, d});
      end else begin
        chk("R6 no strobe", {31'b0, s_pix}, 0);
      end
      if (off >= 5'h14 && off <= 5'h17) begin
        chk("R8 bank strobe", {28'b0, s_pal}, 32'(1 << (off - 20)));
        chk("R8 bank data", {16'b0, s_pald}, {16'b0, d});
      end else begin
        chk("R8 no bank strobe", {28'b0, s_pal}, 0);
      end
      case (off)
        16: m_dl = d;
        17: m_op = d[7:0];
        18: m_col = d[7:0];
        19: m_mode = d[7:0];
        default: ;
      endcase
      bus_read_reg(5'h15, v); chk("R2 R3 R11 x", {16'b0, v}, {16'b0, ex});
      bus_read_reg(5'h16, v); chk("R2 R3 R11 y", {16'b0, v}, {16'b0, ey});
      if (off >= 16 && off < 20) begin
        bus_read_reg(5'(off), v);
        chk("R7 readback", {16'b0, v}, off == 16 ? {16'b0, d} : {24'b0, d[7:0]});
        chk("R7 dest_line", {16'b0, dest_line}, {16'b0, m_dl});
        chk("R7 pix_op", {24'b0, pix_op}, {24'b0, m_op});
        chk("R7 disp_mode", {24'b0, disp_mode}, {24'b0, m_mode});
      end
      if (off >= 24) begin
        bus_read_reg(5'h10, v); chk("R11 dline", {16'b0, v}, {16'b0, m_dl});
        bus_read_reg(5'h11, v); chk("R11 op", {16'b0, v}, {24'b0, m_op});
        bus_read_reg(5'h12, v); chk("R11 colour", {16'b0, v}, {24'b0, m_col});
        bus_read_reg(5'h13, v); chk("R11 mode", {16'b0, v}, {24'b0, m_mode});
      end
    end

    // read sweep over every offset
    for (int off = 0; off < 32; off++) begin
      xa = 16'h0400 + 16'(off * 5);
      ya = 16'h0800 + 16'(off);
      scanline = 16'd1000 + 16'(off * 37);
      bus_write(5'h01, xa);
      bus_write(5'h06, ya);
      ex = xa; ey = ya;
      case (off)
        0, 8: bus_read_pix(5'(off), off % 3, 16'hA000 + 16'(off), ex, ey);
        2, 10: begin ey = ya + 16'd1; bus_read_pix(5'(off), off % 3, 16'hA000 + 16'(off), ex, ey); end
        5, 13: begin ex = xa + 16'd1; bus_read_pix(5'(off), off % 3, 16'hA000 + 16'(off), ex, ey); end
        default: begin
          bus_read_reg(5'(off), v);
          case (off)
            16: chk("R9 dline", {16'b0, v}, {16'b0, m_dl});
            17: chk("R9 op", {16'b0, v}, {24'b0, m_op});
            18: chk("R9 colour", {16'b0, v}, {24'b0, m_col});
            19: chk("R9 mode", {16'b0, v}, {24'b0, m_mode});
            20: chk("R9 line mod", {16'b0, v}, 32'(scanline % 16'd11));
            21: chk("R9 x", {16'b0, v}, {16'b0, xa});
            22: chk("R9 y", {16'b0, v}, {16'b0, ya});
            default: chk("R9 zero", {16'b0, v}, 0);
          endcase
        end
      endcase
      bus_read_reg(5'h15, v); chk("R10 x after", {16'b0, v}, {16'b0, ex});
      bus_read_reg(5'h16, v); chk("R10 y after", {16'b0, v}, {16'b0, ey});
    end

    // R9 modulo corners
    scanline = 16'd0;     bus_read_reg(5'h14, v); chk("R9 mod 0", {16'b0, v}, 0);
    scanline = 16'd10;    bus_read_reg(5'h14, v); chk("R9 mod 10", {16'b0, v}, 10);
    scanline = 16'd11;    bus_read_reg(5'h14, v); chk("R9 mod 11", {16'b0, v}, 0);
    scanline = 16'hFFFF;  bus_read_reg(5'h14, v); chk("R9 mod max", {16'b0, v}, 8);

    // R3 wrap
    bus_write(5'h01, 16'hFFFF);
    bus_write(5'h05, 16'h0);
    bus_read_reg(5'h15, v); chk("R3 x wrap", {16'b0, v}, 0);
    bus_write(5'h06, 16'hFFFF);
    bus_read_pix(5'h0A, 1, 16'h1357, 16'h0000, 16'h0000);

    // R12 request during an outstanding fetch is ignored
    bus_write(5'h01, 16'h0042);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 5'h00;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h09; bus_wdata = 16'h7777;
    @(negedge clk);
    chk("R12 no strobe", {31'b0, pix_wr_stb}, 0);
    bus_addr = 5'h14;
    @(negedge clk);
    chk("R12 no bank strobe", {28'b0, pal_wr_stb}, 0);
    bus_req = 1'b0;
    pix_rd_ack = 1'b1; pix_rd_data = 16'h2468;
    @(negedge clk);
    pix_rd_ack = 1'b0;
    chk("R12 data", {16'b0, rd_data}, 32'h2468);
    bus_read_reg(5'h15, v); chk("R12 x kept", {16'b0, v}, 32'h42);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule